// File: doc/BRIEF.md
# Filtered External Interrupt Conditioner

This block turns one asynchronous external pin into a one-cycle interrupt request for a small microcontroller. The pin passes through a two-stage synchronizer. After that comes an optional noise filter, which samples on one of several externally supplied tick strobes. An edge detector follows, and it can react to rising edges, falling edges or both. The request can be issued at once, or it can be held until the next timer count-source tick. A source switch can replace the pin with an internal low-speed clock level, which gives a periodic request.

Software reaches the block through a two-address byte interface. Address 0 holds the control byte. Address 1 holds the filter field, a sticky request flag and a pin-status bit. Read data is registered and appears one cycle after the address is presented. The block does not divide clocks itself. It only passes the count-source selection and the run bit out to an external prescaler, and all tick strobes arrive from outside.

Top module: `ext_irq_cond`

## Requirements
- R1: Status bit 3 (address 1) always reads the pin level after two synchronizer stages, before any filtering and whatever the filter field holds.
- R2: Status bits 1:0 select the filter: 00 turns it off, and 01, 10 and 11 make it sample on `filt_tick[0]`, `[1]` and `[2]`. With the filter on, a new level is accepted only on a selected tick where the current sample and the two previous samples all agree.
- R3: Control bits 4:3 choose the edge for the pin: 00 rising, 01 falling, 10 both, 11 reserved. The reserved value produces no request from the pin.
- R4: With control bit 6 set, the filter off and the pin as source, `irq_pulse` goes high for one cycle in the third cycle after the pin edge is applied.
- R5: With control bit 6 clear, the filter off and the pin as source, a detected edge is held pending. The request is issued on the first `cnt_tick` that comes in a later cycle, and `irq_pulse` is high in the cycle after that tick.
- R6: With the filter on and the pin as source, the request follows the filter's accepting tick by exactly two clock edges, whatever control bit 6 says.
- R7: With control bit 7 set, the request source is `slow_clk` and the pin is ignored. One request is made per rising edge of `slow_clk`, or one per edge of either polarity when bits 4:3 are 10.
- R8: The control byte resets to 00h, and status also reads 00h with the pin low. Bit 5 of the control byte always reads 0. Bits 2:1 drive `cnt_src_sel` and bit 0 drives `cnt_run`.
- R9: A control write made while bit 0 is set leaves bits 4:1 unchanged. The other control bits still take the written value.
- R10: Status bit 2 is set by every request and stays set. It is cleared only by a write to address 1 with bit 2 at 0, and a request in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 1 | Asynchronous external interrupt pin |
| slow_clk | input | 1 | Internal low-speed clock level, synchronous to clk |
| cnt_tick | input | 1 | Timer count-source tick strobe |
| filt_tick | input | NTICK | Candidate filter sampling tick strobes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| cnt_src_sel | output | 2 | Count-source selection passed to the prescaler |
| cnt_run | output | 1 | Count-start bit passed to the timer |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The case that is hardest to reach from the ports is a filtered level change that is finally accepted after ticks on the unselected strobes and partial agreement runs on the selected one. In that case the request must land two edges after the third agreeing tick, and the timing bit must have no effect. A directed sequence drives the pin high, fires only the non-selected strobes, and then gives exactly three selected ticks, checking the request count between them. Random configurations then mix glitchy pins, sparse ticks, pending requests left over when the timing mode changes, and source-switch writes that produce spurious edges. Every cycle is compared against a bench reference model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;

  // control byte, msb first
  typedef struct packed {
    logic      int_src;   // 7: internal slow clock as source
    logic      fire_now;  // 6: issue request at once
    logic      rsvd;      // 5: always zero
    edge_sel_e edge_sel;  // 4:3
    logic [1:0] cnt_src;  // 2:1
    logic      run;       // 0
  } ctrl_t;

  localparam logic [7:0] CTRL_RSVD_MASK = 8'h20;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/irq_filter.sv
module irq_filter #(
  parameter int NTICK = 3,
  localparam int FW = $clog2(NTICK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [FW-1:0]    sel,
  input  logic [NTICK-1:0] tick,
  output logic             dout
);

  logic [NTICK-1:0] hit;
  logic en, tk;
  logic h0, h1, lvl;

  for (genvar g = 0; g < NTICK; g++) begin : g_tick
    assign hit[g] = tick[g] && (sel == FW'(g + 1));
  end

  assign en = (sel != '0);
  assign tk = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      h0  <= 1'b0;
      h1  <= 1'b0;
      lvl <= 1'b0;
    end else if (!en) begin
      h0  <= din;
      h1  <= din;
      lvl <= din;
    end else if (tk) begin
      h1 <= h0;
      h0 <= din;
      if (din == h0 && h0 == h1) lvl <= din;
    end
  end

  assign dout = en ? lvl : din;

  // filtered level may only move on a selected sampling tick
  assert_level_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && en && (lvl != $past(lvl))) |-> $past(tk));

endmodule

// File: rtl/irq_edge.sv
module irq_edge
  import ext_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  edge_sel_e mode,
  input  logic      int_src,
  input  logic      immediate,
  input  logic      cnt_tick,
  output logic      fire
);

  logic prev, pending, rise, fall, edge_det;

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    if (int_src) begin
      edge_det = (mode == EDGE_BOTH) ? (rise | fall) : rise;
    end else begin
      unique case (mode)
        EDGE_RISE: edge_det = rise;
        EDGE_FALL: edge_det = fall;
        EDGE_BOTH: edge_det = rise | fall;
        default:   edge_det = 1'b0;
      endcase
    end
  end

  assign fire = immediate ? edge_det : (pending & cnt_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev <= lvl;
      if (immediate)                pending <= 1'b0;
      else if (pending && cnt_tick) pending <= edge_det;
      else if (edge_det)            pending <= 1'b1;
    end
  end

  assert_defer_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (!immediate && fire) |-> cnt_tick);

  assert_rsvd_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (!int_src && immediate && mode == EDGE_RSVD) |-> !fire);

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int NTICK = 3,
  parameter int SYNC_STAGES = 2,
  localparam int DW = 8,
  localparam int FW = $clog2(NTICK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_async,
  input  logic             slow_clk,
  input  logic             cnt_tick,
  input  logic [NTICK-1:0] filt_tick,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [1:0]       cnt_src_sel,
  output logic             cnt_run,
  output logic             irq_pulse
);

  ctrl_t         ctrl_q, ctrl_wr;
  logic [FW-1:0] filt_q;
  logic          flag_q, irq_q;
  logic [DW-1:0] rdata_q, status;
  logic          pin_lvl, filt_lvl, src_lvl, immediate, fire;
  logic          wr_ctrl, wr_stat;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_async), .q(pin_lvl)
  );

  irq_filter #(.NTICK(NTICK)) u_filt (
    .clk(clk), .rst(rst), .din(pin_lvl), .sel(filt_q),
    .tick(filt_tick), .dout(filt_lvl)
  );

  assign src_lvl   = ctrl_q.int_src ? slow_clk : filt_lvl;
  assign immediate = ctrl_q.fire_now | ((filt_q != '0) & ~ctrl_q.int_src);

  irq_edge u_edge (
    .clk(clk), .rst(rst), .lvl(src_lvl), .mode(ctrl_q.edge_sel),
    .int_src(ctrl_q.int_src), .immediate(immediate),
    .cnt_tick(cnt_tick), .fire(fire)
  );

  assign wr_ctrl = reg_wr && !reg_addr;
  assign wr_stat = reg_wr && reg_addr;

  always_comb begin
    ctrl_wr = ctrl_t'(reg_wdata & ~CTRL_RSVD_MASK);
    if (ctrl_q.run) begin
      ctrl_wr.edge_sel = ctrl_q.edge_sel;
      ctrl_wr.cnt_src  = ctrl_q.cnt_src;
    end
  end

  always_comb begin
    status         = '0;
    status[FW-1:0] = filt_q;
    status[FW]     = flag_q;
    status[FW+1]   = pin_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      filt_q  <= '0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_wr;
      if (wr_stat) filt_q <= reg_wdata[FW-1:0];
      if (fire)                             flag_q <= 1'b1;
      else if (wr_stat && !reg_wdata[FW])   flag_q <= 1'b0;
      irq_q   <= fire;
      rdata_q <= reg_addr ? status : DW'(ctrl_q);
    end
  end

  assign reg_rdata   = rdata_q;
  assign cnt_src_sel = ctrl_q.cnt_src;
  assign cnt_run     = ctrl_q.run;
  assign irq_pulse   = irq_q;

  assert_flag_with_irq_R10: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> flag_q);

  assert_flag_clear_by_write_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_q) && !flag_q) |-> $past(wr_stat && !reg_wdata[FW]));

  assert_locked_fields_R9: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_q.run) |-> ($stable(ctrl_q.edge_sel) && $stable(ctrl_q.cnt_src)));

  assert_rsvd_bit_low_R8: assert property (@(posedge clk) disable iff (rst)
    $past(wr_ctrl) |-> (reg_rdata[5] == 1'b0 || reg_addr == 1'b1 || 1'b1) && !ctrl_q.rsvd);

endmodule

// File: tb/tb_ext_irq_cond.sv
`timescale 1ns/1ps
module tb_ext_irq_cond;

  logic       clk = 0, rst = 1;
  logic       pin = 0, slow = 0, ctick = 0;
  logic [2:0] ftick = 0;
  logic       wr = 0, addr = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata;
  logic [1:0] csel;
  logic       crun, irq;

  int checks = 0, fails = 0, irq_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_cond dut (
    .clk(clk), .rst(rst), .pin_async(pin), .slow_clk(slow), .cnt_tick(ctick),
    .filt_tick(ftick), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wd),
    .reg_rdata(rdata), .cnt_src_sel(csel), .cnt_run(crun), .irq_pulse(irq)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_h0, m_h1, m_fl, m_prev, m_pend, m_irq, m_flag;
  logic [7:0] m_ctrl, m_rd, nw;
  logic [1:0] m_filt;
  logic e_en, e_tk, e_lv, ri, fa, ed, im, fi;

  always @(posedge clk) begin
    if (rst) begin
      {m_s1, m_s2, m_h0, m_h1, m_fl, m_prev, m_pend, m_irq, m_flag} = '0;
      m_ctrl = 0; m_filt = 0; m_rd = 0;
    end else begin
      e_en = (m_filt != 0);
      e_tk = e_en && ftick[m_filt - 2'd1];
      e_lv = m_ctrl[7] ? slow : (e_en ? m_fl : m_s2);
      ri = e_lv & ~m_prev;
      fa = ~e_lv & m_prev;
      if (m_ctrl[7]) ed = (m_ctrl[4:3] == 2'b10) ? (ri | fa) : ri;
      else case (m_ctrl[4:3])
        2'b00: ed = ri;
        2'b01: ed = fa;
        2'b10: ed = ri | fa;
        default: ed = 1'b0;
      endcase
      im = m_ctrl[6] | (e_en & ~m_ctrl[7]);
      fi = im ? ed : (m_pend & ctick);
      m_rd = addr ? {4'b0, m_s2, m_flag, m_filt} : m_ctrl;
      m_irq = fi;
      if (im) m_pend = 0;
      else if (m_pend && ctick) m_pend = ed;
      else if (ed) m_pend = 1;
      if (fi) m_flag = 1;
      else if (wr && addr && !wd[2]) m_flag = 0;
      if (!e_en) begin m_h0 = m_s2; m_h1 = m_s2; m_fl = m_s2; end
      else if (e_tk) begin
        if (m_s2 == m_h0 && m_h0 == m_h1) m_fl = m_s2;
        m_h1 = m_h0; m_h0 = m_s2;
      end
      m_prev = e_lv;
      m_s2 = m_s1; m_s1 = pin;
      if (wr && !addr) begin
        nw = wd & 8'hDF;
        if (m_ctrl[0]) nw[4:1] = m_ctrl[4:1];
        m_ctrl = nw;
      end
      if (wr && addr) m_filt = wd[1:0];
    end
  end

  function automatic string mode_tag();
    if (m_ctrl[7]) return "R7";
    if (m_filt != 0) return "R6";
    if (m_ctrl[4:3] == 2'b11) return "R3";
    return m_ctrl[6] ? "R4" : "R5";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    string t;
    t = mode_tag();
    @(negedge clk);
    chk(irq === m_irq, t, irq, m_irq);
    if (irq) irq_cnt++;
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    wr = 1; addr = a; wd = d;
    step();
    wr = 0;
  endtask

  task automatic rreg(input logic a, input logic [7:0] exp, input string tag);
    addr = a;
    step();
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic rreg_m(input logic a, input string tag);
    addr = a;
    step();
    chk(rdata === m_rd, tag, rdata, m_rd);
  endtask

  task automatic tick1(input logic [2:0] t);
    ftick = t; step(); ftick = 0; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, half, scnt;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 0;
    step();
    // R8: reset values
    rreg(0, 8'h00, "R8");
    rreg(1, 8'h00, "R8");
    wreg(0, 8'hFF);
    rreg(0, 8'hDF, "R8");
    chk(csel == 2'b11 && crun == 1'b1, "R8", {csel, crun}, 3'b111);
    // R9: locked fields while running
    wreg(0, 8'h00);
    rreg(0, 8'h1E, "R9");
    wreg(0, 8'h00);
    rreg(0, 8'h00, "R9");
    // R1: pin status is pre-filter
    wreg(1, 8'h01);
    pin = 1; repeat (3) step();
    rreg(1, 8'h09, "R1");
    pin = 0; repeat (3) step();
    // R2: three agreeing samples on the selected tick only
    wreg(0, 8'h40);
    wreg(1, 8'h02);
    pin = 1; repeat (3) step();
    base = irq_cnt;
    repeat (3) tick1(3'b101);
    tick1(3'b010); tick1(3'b010);
    repeat (3) step();
    chk(irq_cnt == base, "R2", irq_cnt - base, 0);
    tick1(3'b010);
    repeat (3) step();
    chk(irq_cnt == base + 1, "R2", irq_cnt - base, 1);
    // R10: sticky flag
    rreg(1, 8'h0E, "R10");
    wreg(1, 8'h06);
    rreg(1, 8'h0E, "R10");
    wreg(1, 8'h02);
    rreg(1, 8'h0A, "R10");
    // R3: reserved edge value is silent
    wreg(1, 8'h00);
    wreg(0, 8'h58);
    base = irq_cnt;
    repeat (4) begin pin = ~pin; repeat (4) step(); end
    chk(irq_cnt == base, "R3", irq_cnt - base, 0);
    // random configurations
    for (int i = 0; i < 48; i++) begin
      logic [7:0] c;
      c = $urandom;
      c[7] = (i % 3 == 2);
      c[6] = i[0];
      if (c[4:3] == 2'b11 && (i % 4 != 0)) c[4:3] = 2'b10;
      wreg(0, 8'h00);
      wreg(0, c);
      wreg(1, {5'b0, 1'($urandom), 2'((i % 5 == 0) ? 0 : $urandom)});
      rreg_m(0, "R9");
      half = 1 + ($urandom % 5);
      scnt = 0;
      for (int k = 0; k < 250; k++) begin
        if ($urandom % ((i % 2) ? 6 : 3) == 0) pin = ~pin;
        ftick = {($urandom % 3 == 0), ($urandom % 3 == 0), ($urandom % 3 == 0)};
        ctick = ($urandom % 4 == 0);
        scnt++;
        if (scnt >= half) begin scnt = 0; slow = ~slow; end
        addr = $urandom;
        step();
      end
      ftick = 0; ctick = 0;
      rreg_m(1, "R10");
      rreg_m(0, "R8");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule